// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Acceptance Unit

This block sits beside a small CPU core and decides whether one of its maskable interrupt sources is taken, which one, and when. Each source has a sticky request flag that a one-cycle set pulse raises. It also has a mask bit and a one-bit level bit from the core's registers, where a level of 0 means high. The unit applies the global enable flag, the in-service level flag and a non-maskable busy indication. From the sources that are allowed, it picks one winner.

After it accepts a source, a fixed-length sequencer waits out the pipeline. It then writes the status word and the program counter to a stack-write port, in that order, and strobes a program-counter load with the winner's vector-table address. A return request runs the reverse: two stack pops that restore the program counter, then the status word. The status word carries the enable bit and the level bit back into the unit.

A stall input marks an instruction that is still executing. Acceptance waits for the stall to drop, so the latency can stretch beyond its fixed minimum.

Top module: `irq_accept`

## Requirements
- R1: A source is a candidate only while its request flag is 1 and its mask bit is 0.
- R2: Nothing is accepted while the enable flag is 0. The enable flag resets to 0, `ie_set_i` sets it and `ie_clr_i` clears it; clear wins when both are high.
- R3: While the in-service level flag is 0, a source whose level bit is 1 is not accepted.
- R4: While `nmi_busy_i` is 1, no source is accepted, whatever the enable flag holds.
- R5: Among candidates, a level-0 source beats a level-1 source. Within one level, the lowest source index wins.
- R6: A request that is blocked stays pending in `pend_o` and is accepted once the block clears.
- R7: On acceptance the unit pushes the status word first. The status word is zero-extended and laid out as bit 7 = enable, bit 6 = level flag, bits 5:0 = `flags_i`, all captured before the acceptance. It then pushes `pc_i`. It clears the enable flag, copies the winner's level bit into the level flag, and loads the program counter with VEC_BASE + 2 × source index.
- R8: With no stall and no block, `pc_load_o` for the vector rises LAT_HI (7) clock edges after the edge that registers the request for a level-0 source, and LAT_HI+1 (8) edges after it for a level-1 source.
- R9: The winner's request flag is cleared on the acceptance edge, unless a set pulse for that source arrives in the acceptance cycle. In that case the flag stays 1.
- R10: A `reti_i` pulse while idle pops twice. The first pop loads the program counter from `stk_rdata_i`. The second pop restores enable from bit 7 and the level flag from bit 6, and drives bits 5:0 on `flags_o` with `flags_load_o`. Stack read data is valid in the same cycle as the pop strobe.
- R11: After reset the enable flag is 0, the level flag is 1, all request flags are 0 and no stack or load strobe is active.
- R12: While `insn_busy_i` is 1, no acceptance happens. With all else allowed, acceptance occurs in the first cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set_i | input | N_SRC | One-cycle set pulses for the request flags |
| mask_i | input | N_SRC | Mask bits, 1 = masked |
| prio_i | input | N_SRC | Level bits, 0 = high |
| ie_set_i | input | 1 | Set the enable flag |
| ie_clr_i | input | 1 | Clear the enable flag |
| nmi_busy_i | input | 1 | Non-maskable handler running |
| insn_busy_i | input | 1 | Instruction still executing |
| reti_i | input | 1 | Return-from-interrupt pulse |
| pc_i | input | PC_W | Current program counter |
| flags_i | input | 6 | Core condition flags |
| stk_rdata_i | input | PC_W | Stack top, valid with the pop strobe |
| pend_o | output | N_SRC | Request flags |
| ack_o | output | 1 | Acceptance strobe |
| ack_idx_o | output | IDX_W | Winning source index, valid with `ack_o` |
| ie_o | output | 1 | Enable flag |
| isp_o | output | 1 | In-service level flag |
| stk_push_o | output | 1 | Stack write strobe |
| stk_pop_o | output | 1 | Stack pop strobe |
| stk_wdata_o | output | PC_W | Stack write data |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_addr_o | output | PC_W | Program counter load value |
| flags_load_o | output | 1 | Restore strobe for the core flags |
| flags_o | output | 6 | Restored core flags |

## Verification
The embedded properties assume three things about the inputs. `reti_i` arrives only while a frame pushed by this unit sits on top of the stack. `stk_rdata_i` shows that top during each pop. The mask and level bits stay steady across the cycle that accepts a source. The stimulus holds `mask_i` and `prio_i` fixed except for unmasking between sequences, and models the stack as a bench-side LIFO fed only by the push strobe. It issues each return pulse only after the previous acceptance has finished its vector load. These rules keep the acceptance, push-order and restore properties relating genuine cycles rather than undefined stack contents.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int FLAG_W = 6;
    localparam int PSW_W  = FLAG_W + 2;

    // Stored status word: enable in the top bit, level flag below it.
    typedef struct packed {
        logic              ie;
        logic              isp;
        logic [FLAG_W-1:0] flags;
    } psw_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_PSW,
        SQ_PC,
        SQ_VEC,
        SQ_RPC,
        SQ_RPSW
    } seq_st_e;

    function automatic psw_t psw_make(input logic ie, input logic isp,
                                      input logic [FLAG_W-1:0] flags);
        psw_t w;
        w.ie    = ie;
        w.isp   = isp;
        w.flags = flags;
        return w;
    endfunction

endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);

    // One sticky flag per source; a set pulse beats a clear in the same cycle.
    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_o[g] <= 1'b0;
            end else if (set_i[g]) begin
                pend_o[g] <= 1'b1;
            end else if (clr_i[g]) begin
                pend_o[g] <= 1'b0;
            end
        end
    end

    // R9
    set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R9
    clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] mask_i,
    input  logic [N_SRC-1:0] prio_i,
    input  logic             isp_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             lo_o
);

    logic [N_SRC-1:0] cand_hi;
    logic [N_SRC-1:0] cand_lo;
    logic [N_SRC-1:0] cand_sel;

    for (genvar g = 0; g < N_SRC; g++) begin : g_cand
        assign cand_hi[g] = pend_i[g] & ~mask_i[g] & ~prio_i[g];
        assign cand_lo[g] = pend_i[g] & ~mask_i[g] &  prio_i[g] & isp_i;
    end

    assign cand_sel = (|cand_hi) ? cand_hi : cand_lo;
    assign hit_o    = |cand_sel;
    assign lo_o     = ~(|cand_hi);

    // Lowest index wins inside the chosen level.
    always_comb begin
        idx_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand_sel[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    // R1
    elig_only_chk: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (pend_i[idx_o] && !mask_i[idx_o]));

    // R3
    isp_block_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_o && !isp_i) |-> !prio_i[idx_o]);

    // R5
    lo_yields_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_o && prio_i[idx_o]) |-> ((pend_i & ~mask_i & ~prio_i) == '0));

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int PC_W   = 16,
    parameter int LAT_HI = 7,
    parameter logic [PC_W-1:0] VEC_BASE = 16'h0004,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CNT_W = $clog2(LAT_HI + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              lo_i,
    input  logic              ie_set_i,
    input  logic              ie_clr_i,
    input  logic              nmi_busy_i,
    input  logic              insn_busy_i,
    input  logic              reti_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [PC_W-1:0]   stk_rdata_i,
    output logic              go_o,
    output logic [N_SRC-1:0]  clr_o,
    output logic              ie_o,
    output logic              isp_o,
    output logic              stk_push_o,
    output logic              stk_pop_o,
    output logic [PC_W-1:0]   stk_wdata_o,
    output logic              pc_load_o,
    output logic [PC_W-1:0]   pc_addr_o,
    output logic              flags_load_o,
    output logic [FLAG_W-1:0] flags_o
);

    // Wait cycles so the vector load lands LAT_HI (or LAT_HI+1) edges after
    // the registering edge: accept edge + wait + status + pc + vector.
    localparam logic [CNT_W-1:0] WAIT_HI = CNT_W'(LAT_HI - 4);
    localparam logic [CNT_W-1:0] WAIT_LO = CNT_W'(LAT_HI - 3);

    seq_st_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             ie_q, isp_q;
    psw_t             snap_psw_q;
    logic [PC_W-1:0]  snap_pc_q;
    logic [IDX_W-1:0] win_q;
    psw_t             pop_psw;
    logic [PC_W-1:0]  vec_addr;

    assign pop_psw  = psw_t'(stk_rdata_i[PSW_W-1:0]);
    assign vec_addr = VEC_BASE + PC_W'({win_q, 1'b0});

    assign go_o = (st_q == SQ_IDLE) && !reti_i && !insn_busy_i
                  && ie_q && !nmi_busy_i && hit_i;
    assign clr_o = go_o ? (N_SRC'(1) << idx_i) : '0;

    always_comb begin
        st_d = st_q;
        case (st_q)
            SQ_IDLE: begin
                if (reti_i) begin
                    st_d = SQ_RPC;
                end else if (go_o) begin
                    st_d = SQ_WAIT;
                end
            end
            SQ_WAIT: if (cnt_q == '0) st_d = SQ_PSW;
            SQ_PSW:  st_d = SQ_PC;
            SQ_PC:   st_d = SQ_VEC;
            SQ_VEC:  st_d = SQ_IDLE;
            SQ_RPC:  st_d = SQ_RPSW;
            SQ_RPSW: st_d = SQ_IDLE;
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= SQ_IDLE;
            cnt_q      <= '0;
            ie_q       <= 1'b0;
            isp_q      <= 1'b1;
            snap_psw_q <= '0;
            snap_pc_q  <= '0;
            win_q      <= '0;
        end else begin
            st_q <= st_d;
            if (go_o) begin
                cnt_q      <= lo_i ? WAIT_LO : WAIT_HI;
                snap_psw_q <= psw_make(ie_q, isp_q, flags_i);
                snap_pc_q  <= pc_i;
                win_q      <= idx_i;
            end else if (st_q == SQ_WAIT && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (go_o) begin
                ie_q  <= 1'b0;
                isp_q <= lo_i;
            end else if (st_q == SQ_RPSW) begin
                ie_q  <= pop_psw.ie;
                isp_q <= pop_psw.isp;
            end else if (ie_clr_i) begin
                ie_q <= 1'b0;
            end else if (ie_set_i) begin
                ie_q <= 1'b1;
            end
        end
    end

    always_comb begin
        stk_push_o   = 1'b0;
        stk_pop_o    = 1'b0;
        stk_wdata_o  = '0;
        pc_load_o    = 1'b0;
        pc_addr_o    = '0;
        flags_load_o = 1'b0;
        flags_o      = '0;
        case (st_q)
            SQ_PSW: begin
                stk_push_o  = 1'b1;
                stk_wdata_o = PC_W'(snap_psw_q);
            end
            SQ_PC: begin
                stk_push_o  = 1'b1;
                stk_wdata_o = snap_pc_q;
            end
            SQ_VEC: begin
                pc_load_o = 1'b1;
                pc_addr_o = vec_addr;
            end
            SQ_RPC: begin
                stk_pop_o = 1'b1;
                pc_load_o = 1'b1;
                pc_addr_o = stk_rdata_i;
            end
            SQ_RPSW: begin
                stk_pop_o    = 1'b1;
                flags_load_o = 1'b1;
                flags_o      = pop_psw.flags;
            end
            default: ;
        endcase
    end

    assign ie_o  = ie_q;
    assign isp_o = isp_q;

    // R2
    gate_en_chk: assert property (@(posedge clk) disable iff (rst)
        go_o |-> ie_q);

    // R4
    gate_nmi_chk: assert property (@(posedge clk) disable iff (rst)
        go_o |-> !nmi_busy_i);

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        insn_busy_i |-> !go_o);

    // R7
    push_order_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_PSW) |=> (st_q == SQ_PC && stk_push_o));

    // R7
    en_drop_chk: assert property (@(posedge clk) disable iff (rst)
        go_o |=> !ie_q);

    // R10
    pop_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_RPC) |=> (st_q == SQ_RPSW && stk_pop_o));

    // R7
    one_port_op_chk: assert property (@(posedge clk) disable iff (rst)
        !(stk_push_o && stk_pop_o));

endmodule

// File: rtl/irq_accept.sv
module irq_accept
    import irq_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int PC_W   = 16,
    parameter int LAT_HI = 7,
    parameter logic [PC_W-1:0] VEC_BASE = 16'h0004,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  req_set_i,
    input  logic [N_SRC-1:0]  mask_i,
    input  logic [N_SRC-1:0]  prio_i,
    input  logic              ie_set_i,
    input  logic              ie_clr_i,
    input  logic              nmi_busy_i,
    input  logic              insn_busy_i,
    input  logic              reti_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [PC_W-1:0]   stk_rdata_i,
    output logic [N_SRC-1:0]  pend_o,
    output logic              ack_o,
    output logic [IDX_W-1:0]  ack_idx_o,
    output logic              ie_o,
    output logic              isp_o,
    output logic              stk_push_o,
    output logic              stk_pop_o,
    output logic [PC_W-1:0]   stk_wdata_o,
    output logic              pc_load_o,
    output logic [PC_W-1:0]   pc_addr_o,
    output logic              flags_load_o,
    output logic [FLAG_W-1:0] flags_o
);

    logic [N_SRC-1:0] clr;
    logic             hit;
    logic             win_lo;

    irq_req_bank #(.N_SRC(N_SRC)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (req_set_i),
        .clr_i  (clr),
        .pend_o (pend_o)
    );

    irq_pick #(.N_SRC(N_SRC)) u_pick (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend_o),
        .mask_i (mask_i),
        .prio_i (prio_i),
        .isp_i  (isp_o),
        .hit_o  (hit),
        .idx_o  (ack_idx_o),
        .lo_o   (win_lo)
    );

    irq_seq #(
        .N_SRC    (N_SRC),
        .PC_W     (PC_W),
        .LAT_HI   (LAT_HI),
        .VEC_BASE (VEC_BASE)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .hit_i        (hit),
        .idx_i        (ack_idx_o),
        .lo_i         (win_lo),
        .ie_set_i     (ie_set_i),
        .ie_clr_i     (ie_clr_i),
        .nmi_busy_i   (nmi_busy_i),
        .insn_busy_i  (insn_busy_i),
        .reti_i       (reti_i),
        .pc_i         (pc_i),
        .flags_i      (flags_i),
        .stk_rdata_i  (stk_rdata_i),
        .go_o         (ack_o),
        .clr_o        (clr),
        .ie_o         (ie_o),
        .isp_o        (isp_o),
        .stk_push_o   (stk_push_o),
        .stk_pop_o    (stk_pop_o),
        .stk_wdata_o  (stk_wdata_o),
        .pc_load_o    (pc_load_o),
        .pc_addr_o    (pc_addr_o),
        .flags_load_o (flags_load_o),
        .flags_o      (flags_o)
    );

    // R1
    ack_cand_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (pend_o[ack_idx_o] && !mask_i[ack_idx_o]));

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o && !req_set_i[ack_idx_o]) |=> !pend_o[$past(ack_idx_o)]);

    // R7
    isp_copy_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> (isp_o == $past(prio_i[ack_idx_o])));

endmodule

// File: tb/tb_irq_accept.sv
module tb_irq_accept;

    localparam int N    = 8;
    localparam int PW   = 16;
    localparam int LAT  = 7;
    localparam logic [PW-1:0] VB = 16'h0004;

    // event kinds in the scoreboard
    localparam int EV_ACK = 0;
    localparam int EV_PUSH = 1;
    localparam int EV_PCLD = 2;
    localparam int EV_FLG = 3;

    typedef struct {
        int    kind;
        int    val;
        int    cyc;
        string tag;
    } ev_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req_set = '0;
    logic [N-1:0]  mask = '0;
    logic [N-1:0]  prio = 8'h52;  // sources 1, 4, 6 are low level
    logic          ie_set = 1'b0, ie_clr = 1'b0, nmi_busy = 1'b0;
    logic          insn_busy = 1'b0, reti = 1'b0;
    logic [PW-1:0] pc = 16'h1230;
    logic [5:0]    flags = 6'h15;
    logic [PW-1:0] stk_rdata;
    logic [N-1:0]  pend;
    logic          ack, ie, isp, push, pop, pc_load, flags_load;
    logic [2:0]    ack_idx;
    logic [PW-1:0] wdata, pc_addr;
    logic [5:0]    flags_out;

    int  cyc = 0;
    int  checks = 0;
    int  fails = 0;
    bit  done = 0;
    ev_t sb[$];

    logic [PW-1:0] stk_mem [0:15];
    int            sp = 0;

    always #10 clk = ~clk;

    irq_accept dut (
        .clk(clk), .rst(rst), .req_set_i(req_set), .mask_i(mask), .prio_i(prio),
        .ie_set_i(ie_set), .ie_clr_i(ie_clr), .nmi_busy_i(nmi_busy),
        .insn_busy_i(insn_busy), .reti_i(reti), .pc_i(pc), .flags_i(flags),
        .stk_rdata_i(stk_rdata), .pend_o(pend), .ack_o(ack), .ack_idx_o(ack_idx),
        .ie_o(ie), .isp_o(isp), .stk_push_o(push), .stk_pop_o(pop),
        .stk_wdata_o(wdata), .pc_load_o(pc_load), .pc_addr_o(pc_addr),
        .flags_load_o(flags_load), .flags_o(flags_out)
    );

    // bench-side LIFO stack, read data valid with the pop strobe
    assign stk_rdata = (sp > 0) ? stk_mem[sp-1] : '0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (push) begin
                stk_mem[sp] <= wdata;
                sp <= sp + 1;
            end else if (pop) begin
                sp <= sp - 1;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // monitor: pops the scoreboard whenever the design produces an event
    task automatic take(int kind, int val);
        ev_t e;
        checks++;
        if (sb.size() == 0) begin
            fails++;
            $display("FAIL unexpected event kind %0d: actual %0h expected none (cycle %0d)",
                     kind, val, cyc);
            return;
        end
        e = sb.pop_front();
        if (e.kind != kind || e.val != val || (e.cyc >= 0 && e.cyc != cyc)) begin
            fails++;
            $display("FAIL %s: actual kind %0d val %0h cycle %0d expected kind %0d val %0h cycle %0d",
                     e.tag, kind, val, cyc, e.kind, e.val, e.cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (ack)        take(EV_ACK, int'(ack_idx));
            if (push)       take(EV_PUSH, int'(wdata));
            if (pc_load)    take(EV_PCLD, int'(pc_addr));
            if (flags_load) take(EV_FLG, int'(flags_out));
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected finish earlier", cyc);
            report();
        end
    end

    task automatic ticks(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic exp_ev(int kind, int val, int c, string tag);
        ev_t e;
        e.kind = kind; e.val = val; e.cyc = c; e.tag = tag;
        sb.push_back(e);
    endtask

    // driver: one acceptance; creq is the cycle the request was driven, -1 = untimed
    task automatic exp_irq(int idx, int lo, bit isp_before, int creq, string tag);
        exp_ev(EV_ACK, idx, -1, {tag, " R5 winner"});
        exp_ev(EV_PUSH, {8'h00, 1'b1, isp_before, flags}, -1, {tag, " R7 status push"});
        exp_ev(EV_PUSH, int'(pc), -1, {tag, " R7 pc push"});
        exp_ev(EV_PCLD, int'(VB) + 2 * idx, (creq < 0) ? -1 : creq + 1 + LAT + lo,
               {tag, " R8 vector load"});
    endtask

    task automatic exp_ret(logic [PW-1:0] rpc, string tag);
        exp_ev(EV_PCLD, int'(rpc), -1, {tag, " R10 pc pop"});
        exp_ev(EV_FLG, int'(flags), -1, {tag, " R10 flags pop"});
    endtask

    task automatic drain(string tag);
        int n = 0;
        while (sb.size() != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL %s: actual %0d events outstanding expected 0", tag, sb.size());
            sb.delete();
        end
        ticks(1);
    endtask

    task automatic pulse_req(logic [N-1:0] v);
        req_set = v; ticks(1); req_set = '0;
    endtask
    task automatic pulse_ei();
        ie_set = 1'b1; ticks(1); ie_set = 1'b0;
    endtask
    task automatic pulse_reti();
        reti = 1'b1; ticks(1); reti = 1'b0;
    endtask

    task automatic peek(string tag, int act, int exp);
        @(negedge clk);
        check(tag, act, exp);
        ticks(1);
    endtask

    initial begin
        int c0;
        ticks(3);
        rst = 1'b0;
        // R11 reset state
        @(negedge clk);
        check("R11 enable after reset", ie, 0);
        check("R11 level flag after reset", isp, 1);
        check("R11 request flags after reset", pend, 0);
        ticks(1);

        // R2: disabled request held pending, taken once enabled
        pulse_req(8'h08);
        ticks(10);
        @(negedge clk); check("R2/R6 held while disabled", pend[3], 1); ticks(1);
        c0 = cyc;
        exp_irq(3, 0, 1'b1, c0, "R2 enable");
        pulse_ei();
        drain("R8 high latency");
        @(negedge clk);
        check("R7 enable cleared", ie, 0);
        check("R7 level copied high", isp, 0);
        check("R9 flag cleared", pend[3], 0);
        ticks(1);
        exp_ret(16'h1230, "R10 return");
        pulse_reti();
        drain("R10 return");
        @(negedge clk);
        check("R10 enable restored", ie, 1);
        check("R10 level restored", isp, 1);
        ticks(1);

        // R8 low-level latency
        pc = 16'h2468;
        c0 = cyc;
        exp_irq(4, 1, 1'b1, c0, "R8 low");
        pulse_req(8'h10);
        drain("R8 low latency");
        peek("R7 level copied low", isp, 1);
        exp_ret(16'h2468, "R10 low return");
        pulse_reti();
        drain("R10 low return");

        // R5 simultaneous arbitration
        ie_clr = 1'b1; ticks(1); ie_clr = 1'b0;
        pc = 16'h3000;
        pulse_req(8'hE2);
        c0 = cyc;
        exp_irq(5, 0, 1'b1, c0, "R5 group");
        pulse_ei();
        drain("R5 first");
        peek("R6 others pending", pend, 8'hC2);
        exp_ret(16'h3000, "R5 ret a");
        exp_irq(7, 0, 1'b1, -1, "R5 second");
        pulse_reti();
        drain("R5 second");
        exp_ret(16'h3000, "R5 ret b");
        exp_irq(1, 1, 1'b1, -1, "R5 third");
        pulse_reti();
        drain("R5 third");
        exp_ret(16'h3000, "R5 ret c");
        exp_irq(6, 1, 1'b1, -1, "R5 fourth");
        pulse_reti();
        drain("R5 fourth");
        exp_ret(16'h3000, "R5 ret d");
        pulse_reti();
        drain("R5 ret d");

        // R3 nesting rules
        pc = 16'h4400;
        c0 = cyc;
        exp_irq(4, 1, 1'b1, c0, "R3 outer low");
        pulse_req(8'h10);
        drain("R3 outer low");
        pulse_ei();
        pc = 16'h4500;
        c0 = cyc;
        exp_irq(2, 0, 1'b1, c0, "R3 nested high");
        pulse_req(8'h04);
        drain("R3 nested high");
        pulse_ei();
        pulse_req(8'h40);
        ticks(12);
        peek("R3 low blocked under high", pend[6], 1);
        exp_ret(16'h4500, "R3 ret high");
        exp_irq(6, 1, 1'b1, -1, "R3 low after return");
        pulse_reti();
        drain("R3 low after return");
        exp_ret(16'h4500, "R3 ret low");
        pulse_reti();
        drain("R3 ret low");
        exp_ret(16'h4400, "R3 ret outer");
        pulse_reti();
        drain("R3 ret outer");
        check("R10 stack balanced", sp, 0);

        // R4 non-maskable busy blocks all
        nmi_busy = 1'b1;
        pulse_req(8'h01);
        ticks(10);
        peek("R4 held during nmi", pend[0], 1);
        c0 = cyc;
        exp_irq(0, 0, 1'b1, c0 - 1, "R4 release");
        nmi_busy = 1'b0;
        drain("R4 release");
        exp_ret(16'h4500, "R4 ret");
        pulse_reti();
        drain("R4 ret");

        // R12 stall delays acceptance
        insn_busy = 1'b1;
        pulse_req(8'h08);
        ticks(5);
        peek("R12 held during stall", pend[3], 1);
        c0 = cyc;
        exp_irq(3, 0, 1'b1, c0 - 1, "R12 release");
        insn_busy = 1'b0;
        drain("R12 release");
        exp_ret(16'h4500, "R12 ret");
        pulse_reti();
        drain("R12 ret");

        // R1 mask
        mask = 8'h04;
        pulse_req(8'h04);
        ticks(10);
        peek("R1 masked held", pend[2], 1);
        c0 = cyc;
        exp_irq(2, 0, 1'b1, c0 - 1, "R1 unmask");
        mask = '0;
        drain("R1 unmask");
        exp_ret(16'h4500, "R1 ret");
        pulse_reti();
        drain("R1 ret");

        // R9 set in the acceptance cycle keeps the flag
        c0 = cyc;
        exp_irq(3, 0, 1'b1, c0, "R9 reset race");
        pulse_req(8'h08);
        pulse_req(8'h08);
        drain("R9 reset race");
        peek("R9 flag re-set", pend[3], 1);
        exp_ret(16'h4500, "R9 ret");
        exp_irq(3, 0, 1'b1, -1, "R9 second take");
        pulse_reti();
        drain("R9 second take");
        exp_ret(16'h4500, "R9 ret b");
        pulse_reti();
        drain("R9 ret b");
        check("R10 stack empty", sp, 0);

        done = 1;
        report();
    end

endmodule